// File: doc/BRIEF.md
# Peripheral-End Transfer Terminator

This block ends a DMA transfer early when the attached peripheral raises its end request. The request arrives asynchronously; it is synchronised, and its rising edge arms a termination latch once per assertion. A hold-clear control bit and the clear-FIFO bit both keep the latch cleared. Once armed, the block's behaviour depends on the transfer direction.

For an input transfer, the next word written from the peripheral side carries a marker in a seventeenth bit of the FIFO write word. Later peripheral words are not written. A one-clock data-end pulse is raised towards the backplane, and this ends the transfer whatever the host DMA count holds. For an output transfer, the block answers every service poll positively. It also reports "FIFO can accept" whatever the real FIFO state is. It raises the data-end pulse when the next word arrives from the backplane. The FIFO storage itself lies outside this block.

Top module: `xfer_end_term`

## Requirements
- R1: After reset the latch is clear: peripheral words pass to the FIFO with bit 16 at 0, data-end is 0, and the poll response and ready output follow the native inputs.
- R2: While the hold-clear bit `end_hold_clr` is 1, a peripheral end assertion has no effect: later words are untagged and no data-end occurs.
- R3: With `dir_in` = 1 (input) and the latch armed, the next peripheral word strobe writes the word with bit 16 = 1 and the low 16 bits unchanged.
- R4: After the tagged input word, further peripheral word strobes produce no FIFO write until the latch is cleared.
- R5: In an input termination, data-end is high for exactly the one clock after the terminating strobe.
- R6: With `dir_in` = 0 (output) and the latch set, every service poll is answered positively and the ready output is 1, whatever the native poll and ready inputs are.
- R7: In an output termination, a backplane word strobe raises data-end for exactly the next clock. A backplane strobe while the latch is not armed raises nothing.
- R8: With `dir_in` = 0, peripheral words are never tagged, even while the latch is armed.
- R9: One end assertion arms the latch once. After a clear, an end request that stays high does not re-arm the latch until it falls and rises again.
- R10: `fifo_clr` clears the latch. When a clear and a terminating strobe fall in the same cycle, the clear wins: the word is written untagged and no data-end follows.
- R11: With the latch clear, `poll_resp` equals `svc_poll` AND `poll_ok_native`, and `fifo_rdy_out` equals `fifo_rdy_native`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_in | input | 1 | Transfer direction, 1 = input, 0 = output |
| end_hold_clr | input | 1 | Holds the termination latch clear while 1 |
| fifo_clr | input | 1 | Clear-FIFO control, also clears the latch |
| periph_end_async | input | 1 | Asynchronous end request from the peripheral |
| fp_wr_stb | input | 1 | Peripheral-side word strobe |
| fp_data | input | 16 | Peripheral-side word |
| bp_wr_stb | input | 1 | Backplane word strobe |
| svc_poll | input | 1 | Service poll from the host |
| poll_ok_native | input | 1 | Poll answer from the normal FIFO logic |
| fifo_rdy_native | input | 1 | Real "FIFO can accept" status |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | 17 | FIFO write word, bit 16 is the end marker |
| poll_resp | output | 1 | Poll answer sent to the host |
| fifo_rdy_out | output | 1 | Ready status, possibly overridden |
| data_end | output | 1 | One-clock data-end pulse to the backplane |

## Verification
Two events can land in the same clock: a latch clear from `fifo_clr`, and the strobe that would end the transfer. The bench arms the latch for an input transfer. It then raises `fifo_clr` and a peripheral strobe together. It expects an untagged write in that cycle, no data-end in the next, and an unarmed latch after that. A second collision case raises the end request's synchronised edge while the hold-clear bit is high. The edge must be lost, and it must not re-arm the latch once the bit is released.

// File: rtl/xfer_end_pkg.sv
package xfer_end_pkg;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_ARMED = 2'd1,
        TS_DONE  = 2'd2
    } term_state_t;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } xfer_dir_t;

    function automatic logic is_set(input term_state_t s);
        return (s == TS_ARMED) || (s == TS_DONE);
    endfunction

endpackage

// File: rtl/xfer_end_sync_edge.sv
module xfer_end_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_async,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], din_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev_q;
endmodule

// File: rtl/xfer_end_fsm.sv
module xfer_end_fsm
    import xfer_end_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        dir_in,
    input  logic        end_rise,
    input  logic        fp_stb,
    input  logic        bp_stb,
    output term_state_t state,
    output logic        data_end
);
    term_state_t state_d;
    logic        finish;

    always_comb begin
        finish  = 1'b0;
        state_d = state;
        if (clear) begin
            state_d = TS_IDLE;
        end else begin
            unique case (state)
                TS_IDLE:  if (end_rise) state_d = TS_ARMED;
                TS_ARMED: begin
                    if (dir_in == DIR_IN) finish = fp_stb;
                    else                  finish = bp_stb;
                    if (finish) state_d = TS_DONE;
                end
                TS_DONE:  state_d = TS_DONE;
                default:  state_d = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TS_IDLE;
            data_end <= 1'b0;
        end else begin
            state    <= state_d;
            data_end <= finish;
        end
    end
endmodule

// File: rtl/xfer_end_term.sv
module xfer_end_term
    import xfer_end_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_in,
    input  logic              end_hold_clr,
    input  logic              fifo_clr,
    input  logic              periph_end_async,
    input  logic              fp_wr_stb,
    input  logic [DATA_W-1:0] fp_data,
    input  logic              bp_wr_stb,
    input  logic              svc_poll,
    input  logic              poll_ok_native,
    input  logic              fifo_rdy_native,
    output logic              fifo_we,
    output logic [DATA_W:0]   fifo_wdata,
    output logic              poll_resp,
    output logic              fifo_rdy_out,
    output logic              data_end
);
    localparam int TAG_BIT = DATA_W;

    logic        end_rise;
    logic        clear;
    term_state_t state;
    logic        in_mode;
    logic        tag_now;
    logic        block_fp;
    logic        spoof;

    assign clear = end_hold_clr | fifo_clr;

    xfer_end_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .din_async (periph_end_async),
        .rise      (end_rise)
    );

    xfer_end_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .dir_in   (dir_in),
        .end_rise (end_rise),
        .fp_stb   (fp_wr_stb),
        .bp_stb   (bp_wr_stb),
        .state    (state),
        .data_end (data_end)
    );

    always_comb begin
        in_mode  = (dir_in == DIR_IN);
        tag_now  = in_mode && (state == TS_ARMED) && !clear;
        block_fp = in_mode && (state == TS_DONE);
        spoof    = !in_mode && is_set(state);
    end

    assign fifo_we                 = fp_wr_stb & ~block_fp;
    assign fifo_wdata[DATA_W-1:0]  = fp_data;
    assign fifo_wdata[TAG_BIT]     = tag_now & fp_wr_stb;
    assign poll_resp               = svc_poll & (poll_ok_native | spoof);
    assign fifo_rdy_out            = fifo_rdy_native | spoof;
endmodule

// File: rtl/xfer_end_term_chk.sv
module xfer_end_term_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dir_in,
    input logic              end_hold_clr,
    input logic              fifo_clr,
    input logic              fp_wr_stb,
    input logic              svc_poll,
    input logic              fifo_we,
    input logic [DATA_W:0]   fifo_wdata,
    input logic              poll_resp,
    input logic              data_end
);
    p_end_one_clock_r5: assert property (@(posedge clk) disable iff (rst)
        data_end |=> !data_end);

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (fifo_clr || end_hold_clr) |=> !data_end);

    p_blocked_after_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (data_end && dir_in && fp_wr_stb) |-> !fifo_we);

    p_tag_input_only_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_wdata[DATA_W] |-> (dir_in && fifo_we));

    p_poll_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
        poll_resp |-> svc_poll);

    p_hold_no_tag_r2: assert property (@(posedge clk) disable iff (rst)
        end_hold_clr |=> !fifo_wdata[DATA_W]);
endmodule

bind xfer_end_term xfer_end_term_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dir_in       (dir_in),
    .end_hold_clr (end_hold_clr),
    .fifo_clr     (fifo_clr),
    .fp_wr_stb    (fp_wr_stb),
    .svc_poll     (svc_poll),
    .fifo_we      (fifo_we),
    .fifo_wdata   (fifo_wdata),
    .poll_resp    (poll_resp),
    .data_end     (data_end)
);

// File: tb/test_xfer_end_term.sv
module test_xfer_end_term;
    logic        clk = 1'b0;
    logic        rst;
    logic        dir_in, end_hold_clr, fifo_clr, periph_end_async;
    logic        fp_wr_stb, bp_wr_stb, svc_poll, poll_ok_native, fifo_rdy_native;
    logic [15:0] fp_data;
    logic        fifo_we, poll_resp, fifo_rdy_out, data_end;
    logic [16:0] fifo_wdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    xfer_end_term i_xfer_end_term (
        .clk(clk), .rst(rst), .dir_in(dir_in), .end_hold_clr(end_hold_clr),
        .fifo_clr(fifo_clr), .periph_end_async(periph_end_async),
        .fp_wr_stb(fp_wr_stb), .fp_data(fp_data), .bp_wr_stb(bp_wr_stb),
        .svc_poll(svc_poll), .poll_ok_native(poll_ok_native),
        .fifo_rdy_native(fifo_rdy_native), .fifo_we(fifo_we),
        .fifo_wdata(fifo_wdata), .poll_resp(poll_resp),
        .fifo_rdy_out(fifo_rdy_out), .data_end(data_end)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic arm();
        periph_end_async = 1'b1;
        repeat (4) step();
    endtask

    task automatic drop_end();
        periph_end_async = 1'b0;
        repeat (4) step();
    endtask

    task automatic do_clear();
        fifo_clr = 1'b1;
        step();
        fifo_clr = 1'b0;
    endtask

    task automatic t_reset();
        fp_wr_stb = 1'b1; fp_data = 16'h1234; settle();
        check("R1 we", fifo_we, 1);
        check("R1 word", fifo_wdata, 17'h01234);
        check("R1 data_end", data_end, 0);
        svc_poll = 1'b1; poll_ok_native = 1'b0; fifo_rdy_native = 1'b0; settle();
        check("R11 poll", poll_resp, 0);
        check("R11 rdy", fifo_rdy_out, 0);
        poll_ok_native = 1'b1; fifo_rdy_native = 1'b1; settle();
        check("R11 poll native", poll_resp, 1);
        check("R11 rdy native", fifo_rdy_out, 1);
        fp_wr_stb = 1'b0; svc_poll = 1'b0; poll_ok_native = 1'b0; fifo_rdy_native = 1'b0;
        bp_wr_stb = 1'b1; step(); bp_wr_stb = 1'b0;
        check("R7 idle bp strobe", data_end, 0);
    endtask

    task automatic t_input_term();
        dir_in = 1'b1;
        arm();
        fp_wr_stb = 1'b1; fp_data = 16'hA5A5; settle();
        check("R3 tagged word", fifo_wdata, 17'h1A5A5);
        check("R3 we", fifo_we, 1);
        step(); fp_wr_stb = 1'b0;
        check("R5 data_end high", data_end, 1);
        step();
        check("R5 data_end low", data_end, 0);
        fp_wr_stb = 1'b1; fp_data = 16'h0F0F; settle();
        check("R4 blocked", fifo_we, 0);
        fp_wr_stb = 1'b0;
        do_clear();
        fp_wr_stb = 1'b1; settle();
        check("R10 write after clear", fifo_we, 1);
        check("R9 no rearm while held", fifo_wdata[16], 0);
        step(); fp_wr_stb = 1'b0;
        check("R9 no data_end", data_end, 0);
        drop_end();
    endtask

    task automatic t_output_term();
        dir_in = 1'b0;
        arm();
        svc_poll = 1'b1; poll_ok_native = 1'b0; fifo_rdy_native = 1'b0; settle();
        check("R6 poll forced", poll_resp, 1);
        check("R6 ready forced", fifo_rdy_out, 1);
        fp_wr_stb = 1'b1; fp_data = 16'h5555; settle();
        check("R8 no tag on output", fifo_wdata, 17'h05555);
        fp_wr_stb = 1'b0; svc_poll = 1'b0;
        step();
        check("R8 no data_end from fp", data_end, 0);
        bp_wr_stb = 1'b1; step(); bp_wr_stb = 1'b0;
        check("R7 data_end high", data_end, 1);
        step();
        check("R7 data_end low", data_end, 0);
        do_clear(); settle();
        check("R11 override removed", fifo_rdy_out, 0);
        drop_end();
    endtask

    task automatic t_hold_clear();
        dir_in = 1'b1;
        end_hold_clr = 1'b1;
        arm();
        drop_end();
        end_hold_clr = 1'b0;
        step();
        fp_wr_stb = 1'b1; fp_data = 16'h00FF; settle();
        check("R2 untagged", fifo_wdata, 17'h000FF);
        step(); fp_wr_stb = 1'b0;
        check("R2 no data_end", data_end, 0);
    endtask

    task automatic t_collision();
        dir_in = 1'b1;
        arm();
        fp_wr_stb = 1'b1; fifo_clr = 1'b1; fp_data = 16'hBEEF; settle();
        check("R10 untagged on clear", fifo_wdata, 17'h0BEEF);
        check("R10 written", fifo_we, 1);
        step(); fp_wr_stb = 1'b0; fifo_clr = 1'b0;
        check("R10 no data_end", data_end, 0);
        fp_wr_stb = 1'b1; settle();
        check("R10 not armed", fifo_wdata[16], 0);
        fp_wr_stb = 1'b0;
        drop_end();
        arm();
        fp_wr_stb = 1'b1; fp_data = 16'h0001; settle();
        check("R9 rearm after new edge", fifo_wdata, 17'h10001);
        step(); fp_wr_stb = 1'b0;
        check("R5 second termination", data_end, 1);
        do_clear();
        drop_end();
    endtask

    initial begin
        #150000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; dir_in = 1'b0; end_hold_clr = 1'b0; fifo_clr = 1'b0;
        periph_end_async = 1'b0; fp_wr_stb = 1'b0; fp_data = '0; bp_wr_stb = 1'b0;
        svc_poll = 1'b0; poll_ok_native = 1'b0; fifo_rdy_native = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_input_term();
        t_output_term();
        t_hold_clear();
        t_collision();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule